// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This core collects eight interrupt request lines, keeps each arriving request in a pending register until it is granted, and picks one winner among the pending, unmasked lines. The priority order is circular: a three-bit "bottom" pointer names the lowest level, and the level after it (modulo 8) is the highest. At reset the bottom is level 7, so level 0 is the highest. The winner raises the interrupt output only if it outranks every level now in service, unless special mask mode is on.

The processor grants an interrupt with a one-cycle acknowledge strobe. During that cycle the vector output carries the programmable base plus the winning level. At the end of that cycle the winner's in-service bit is set and its pending bit is cleared. Software uses a small write port to change the mask, the vector base and the mode byte, and to issue end-of-service and rotation commands. Software can also arm a poll. The next read then returns the winning level and counts as the grant, so the interrupt output is not needed.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the mask, pending and in-service registers are zero, the vector base is 0x00, special mask mode and poll are off, the bottom level is 7, int_o is low and rd_data_o reads 0x00.
- R2: A high level on irq_i[n] in any cycle sets pending bit n, which stays set until level n is granted. A grant clears it at the edge that ends the grant cycle, and that clear wins over a new request on the same line in that cycle.
- R3: A write with wr_sel_i=0 loads the mask from wr_data_i, where bit n masks level n. A masked pending level never raises int_o and is never granted. It keeps its pending bit, so clearing the mask bit later raises int_o.
- R4: Priority falls from the level after the bottom, going upward modulo 8, down to the bottom level. With the reset bottom of 7, level 0 is the highest and level 7 the lowest.
- R5: Outside special mask mode, int_o is high only when the highest-priority eligible pending level is strictly higher in priority than every in-service level.
- R6: When ack_i is high and int_o is high, vec_o equals base + winning level (modulo 256) in that cycle. At the edge that ends the cycle, the winner's in-service bit is set and its pending bit is cleared.
- R7: When ack_i is high and int_o is low, vec_o equals base + 7 and the pending and in-service registers do not change.
- R8: A write with wr_sel_i=1 loads the vector base.
- R9: A write with wr_sel_i=2 is a command: bit 5 = end of service, bit 6 = specific, bit 7 = rotate, bits 2:0 = level. With bit 5 set and bit 6 clear, the highest-priority in-service bit is cleared (there is no effect if none is set).
- R10: With bit 5 and bit 6 both set, the command clears the in-service bit of the named level.
- R11: An end-of-service command (R9 or R10) with bit 7 set also moves the bottom to the level it cleared, so the next level up becomes the highest.
- R12: A command with bit 5 clear and both bit 6 and bit 7 set moves the bottom to the named level without touching the in-service bits.
- R13: A write with wr_sel_i=3 sets special mask mode from bit 0. In that mode any unmasked pending level that is not itself in service may raise int_o, whatever else is in service.
- R14: A write with wr_sel_i=3 and bit 1 set arms a poll. While the poll is armed, rd_data_o = {1, 0000, level} if a winner exists and 0x00 otherwise. A rd_en_i cycle disarms the poll and grants that winner as in R6. An empty poll changes no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 8 | Interrupt request lines, one per level |
| ack_i | input | 1 | One-cycle acknowledge (grant) strobe |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector number, valid while ack_i is high |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 mask, 1 base, 2 command, 3 mode |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Poll read strobe |
| rd_data_o | output | 8 | Poll result byte |

## Verification
On every cycle, the assertions check the following: int_o never rises without an unmasked pending level, and the winner shown on the vector is never masked. Outside special mask mode, that winner is never a level already in service. A grant sets the matching in-service bit and clears its pending bit, while a spurious grant or an empty poll leaves the in-service register untouched. The order that results from rotation, whether automatic on end of service or by the set-priority command, is only shown by the bench's scenarios. The same holds for the nesting sequences, for release by special mask mode, and for base wrap-around in the vector.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_i,
  input  logic       ack_i,
  output logic       int_o,
  output logic [7:0] vec_o,
  input  logic       wr_en_i,
  input  logic [1:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_en_i,
  output logic [7:0] rd_data_o
);
  localparam int NLVL = 8;
  localparam int LW   = $clog2(NLVL);

  logic [NLVL-1:0] irr_q, isr_q, mask_q;
  logic [7:0]      base_q;
  logic [LW-1:0]   bot_q;
  logic            smm_q, poll_q;

  logic [NLVL-1:0] elig;
  logic [LW-1:0]   req_lvl, req_pos, svc_lvl, svc_pos;
  logic            req_any, svc_any;

  assign elig = irr_q & ~mask_q & (smm_q ? ~isr_q : {NLVL{1'b1}});

  always_comb begin
    req_any = 1'b0; req_lvl = '0; req_pos = '0;
    svc_any = 1'b0; svc_lvl = '0; svc_pos = '0;
    for (int i = NLVL-1; i >= 0; i--) begin
      if (elig[bot_q + LW'(1) + LW'(i)]) begin
        req_any = 1'b1;
        req_lvl = bot_q + LW'(1) + LW'(i);
        req_pos = LW'(i);
      end
      if (isr_q[bot_q + LW'(1) + LW'(i)]) begin
        svc_any = 1'b1;
        svc_lvl = bot_q + LW'(1) + LW'(i);
        svc_pos = LW'(i);
      end
    end
  end

  assign int_o     = req_any && (smm_q || !svc_any || (req_pos < svc_pos));
  assign vec_o     = base_q + {5'd0, (int_o ? req_lvl : 3'd7)};
  assign rd_data_o = (poll_q && int_o) ? {1'b1, 4'd0, req_lvl} : 8'h00;

  logic            cmd_wr, eoi_hit, rot_set;
  logic [LW-1:0]   eoi_lvl;
  logic            grant;
  logic [NLVL-1:0] set_v, clr_v;

  assign cmd_wr  = wr_en_i && (wr_sel_i == 2'd2);
  assign eoi_lvl = wr_data_i[6] ? wr_data_i[2:0] : svc_lvl;
  assign eoi_hit = cmd_wr && wr_data_i[5] && (wr_data_i[6] || svc_any);
  assign rot_set = cmd_wr && !wr_data_i[5] && wr_data_i[6] && wr_data_i[7];
  assign grant   = int_o && (ack_i || (rd_en_i && poll_q));
  assign set_v   = grant   ? (NLVL'(1) << req_lvl) : '0;
  assign clr_v   = eoi_hit ? (NLVL'(1) << eoi_lvl) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      mask_q <= '0;
      base_q <= 8'h00;
      bot_q  <= LW'(NLVL-1);
      smm_q  <= 1'b0;
      poll_q <= 1'b0;
    end else begin
      irr_q <= (irr_q | irq_i) & ~set_v;
      isr_q <= (isr_q & ~clr_v) | set_v;
      if (rd_en_i) poll_q <= 1'b0;
      if (wr_en_i) begin
        case (wr_sel_i)
          2'd0: mask_q <= wr_data_i;
          2'd1: base_q <= wr_data_i;
          2'd3: begin
            smm_q  <= wr_data_i[0];
            poll_q <= wr_data_i[1];
          end
          default: ;
        endcase
      end
      if (eoi_hit && wr_data_i[7]) bot_q <= eoi_lvl;
      else if (rot_set)            bot_q <= wr_data_i[2:0];
    end
  end
endmodule

module prio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_i,
  input logic       int_o,
  input logic [7:0] vec_o,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic [7:0] rd_data_o,
  input logic [7:0] base_q,
  input logic [7:0] mask_q,
  input logic [7:0] isr_q,
  input logic [7:0] irr_q,
  input logic       smm_q
);
  logic [7:0] vdiff;
  logic [2:0] vlvl;
  assign vdiff = vec_o - base_q;
  assign vlvl  = vdiff[2:0];

  AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((irr_q & ~mask_q) != 8'h00)); // R3
  AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> !mask_q[vlvl]); // R3
  AST_NESTED_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (int_o && !smm_q) |-> !isr_q[vlvl]); // R5
  AST_GRANT_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && int_o && !wr_en_i) |=> isr_q[$past(vlvl)]); // R6
  AST_GRANT_CLEARS_IRR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && int_o) |=> !irr_q[$past(vlvl)]); // R2
  AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o && !wr_en_i && !rd_en_i) |=> (isr_q == $past(isr_q))); // R7
  AST_EMPTY_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && (rd_data_o == 8'h00) && !ack_i && !wr_en_i) |=> (isr_q == $past(isr_q))); // R14
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .int_o(int_o), .vec_o(vec_o),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
  .base_q(base_q), .mask_q(mask_q), .isr_q(isr_q), .irr_q(irr_q), .smm_q(smm_q)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_i = 8'h00;
  logic       ack_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd0;
  logic [7:0] wr_data_i = 8'h00;
  logic       rd_en_i = 1'b0;
  logic       int_o;
  logic [7:0] vec_o, rd_data_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .ack_i(ack_i), .int_o(int_o),
    .vec_o(vec_o), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_int(input bit exp, input string req);
    check(int_o === exp, req, int'(int_o), int'(exp));
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0; #1;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); irq_i = m;
    @(negedge clk); irq_i = 8'h00; #1;
  endtask

  task automatic ack_expect(input logic [7:0] exp, input string req);
    @(negedge clk); ack_i = 1'b1; #1;
    check(vec_o === exp, req, int'(vec_o), int'(exp));
    @(negedge clk); ack_i = 1'b0; #1;
  endtask

  task automatic t_reset;
    chk_int(1'b0, "R1 int low");
    check(rd_data_o === 8'h00, "R1 read", int'(rd_data_o), 0);
    pulse(8'h01);
    ack_expect(8'h00, "R1 base zero");
    wr(2'd2, 8'h20);
    chk_int(1'b0, "R1 after eoi");
  endtask

  task automatic t_fixed;
    pulse(8'hA0);
    chk_int(1'b1, "R2 latched");
    ack_expect(8'h05, "R4 level5 beats level7");
    chk_int(1'b0, "R5 lower blocked");
    wr(2'd2, 8'h20);
    chk_int(1'b1, "R9 eoi releases");
    ack_expect(8'h07, "R6 level7");
    chk_int(1'b0, "R2 cleared by grant");
    wr(2'd2, 8'h20);
    chk_int(1'b0, "R9 idle");
  endtask

  task automatic t_nesting;
    wr(2'd1, 8'h40);
    pulse(8'h08);
    ack_expect(8'h43, "R8 base plus 3");
    pulse(8'h02);
    chk_int(1'b1, "R5 higher nests");
    ack_expect(8'h41, "R5 nested vec");
    pulse(8'h04);
    chk_int(1'b0, "R5 level2 under 1");
    wr(2'd2, 8'h20);
    chk_int(1'b1, "R9 clears 1 first");
    ack_expect(8'h42, "R9 level2 granted");
    wr(2'd2, 8'h20);
    chk_int(1'b0, "R9 level3 still in service");
    wr(2'd2, 8'h20);
    chk_int(1'b0, "R9 all clear");
  endtask

  task automatic t_mask;
    wr(2'd0, 8'h10);
    pulse(8'h10);
    chk_int(1'b0, "R3 masked");
    ack_expect(8'h47, "R7 spurious vec");
    wr(2'd0, 8'h00);
    chk_int(1'b1, "R3 unmask raises");
    ack_expect(8'h44, "R3 pending kept");
    wr(2'd2, 8'h20);
    chk_int(1'b0, "R3 done");
  endtask

  task automatic t_spurious;
    ack_expect(8'h47, "R7 empty ack");
    chk_int(1'b0, "R7 int stays low");
    pulse(8'h80);
    chk_int(1'b1, "R7 no isr7 set");
    ack_expect(8'h47, "R7 real level7");
    wr(2'd2, 8'h20);
  endtask

  task automatic t_auto_rot;
    pulse(8'h04);
    ack_expect(8'h42, "R11 grant 2");
    wr(2'd2, 8'hA0);
    pulse(8'h0A);
    ack_expect(8'h43, "R11 level3 now highest");
    wr(2'd2, 8'h20);
    ack_expect(8'h41, "R11 then level1");
    wr(2'd2, 8'h20);
    chk_int(1'b0, "R11 idle");
  endtask

  task automatic t_spec_rot;
    wr(2'd2, 8'hC6);
    pulse(8'h81);
    ack_expect(8'h47, "R12 level7 highest");
    wr(2'd2, 8'h67);
    chk_int(1'b1, "R10 specific eoi");
    ack_expect(8'h40, "R12 then level0");
    wr(2'd2, 8'h60);
    chk_int(1'b0, "R10 cleared");
    wr(2'd2, 8'hC7);
    pulse(8'h10);
    ack_expect(8'h44, "R12 restored");
    wr(2'd2, 8'hE4);
    pulse(8'h21);
    ack_expect(8'h45, "R11 specific rotate");
    wr(2'd2, 8'h20);
    ack_expect(8'h40, "R11 level0 after 5");
    wr(2'd2, 8'h20);
    wr(2'd2, 8'hC7);
  endtask

  task automatic t_smm;
    pulse(8'h01);
    ack_expect(8'h40, "R13 grant 0");
    pulse(8'h40);
    chk_int(1'b0, "R13 nested blocks");
    wr(2'd3, 8'h01);
    chk_int(1'b1, "R13 smm releases");
    ack_expect(8'h46, "R13 level6 granted");
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h20);
    wr(2'd2, 8'h20);
    chk_int(1'b0, "R13 cleared");
  endtask

  task automatic t_poll;
    pulse(8'h24);
    wr(2'd3, 8'h02);
    check(rd_data_o === 8'h82, "R14 poll byte", int'(rd_data_o), 8'h82);
    @(negedge clk); rd_en_i = 1'b1;
    @(negedge clk); rd_en_i = 1'b0; #1;
    check(rd_data_o === 8'h00, "R14 disarmed", int'(rd_data_o), 0);
    chk_int(1'b0, "R14 poll acted as grant");
    wr(2'd2, 8'h20);
    ack_expect(8'h45, "R14 level5 next");
    wr(2'd2, 8'h20);
    wr(2'd3, 8'h02);
    check(rd_data_o === 8'h00, "R14 empty poll", int'(rd_data_o), 0);
    @(negedge clk); rd_en_i = 1'b1;
    @(negedge clk); rd_en_i = 1'b0; #1;
    pulse(8'h80);
    chk_int(1'b1, "R14 empty poll no isr");
    ack_expect(8'h47, "R14 level7");
    wr(2'd2, 8'h20);
  endtask

  task automatic t_clear_wins;
    pulse(8'h08);
    @(negedge clk); ack_i = 1'b1; irq_i = 8'h08; #1;
    check(vec_o === 8'h43, "R6 vec", int'(vec_o), 8'h43);
    @(negedge clk); ack_i = 1'b0; irq_i = 8'h00; #1;
    wr(2'd2, 8'h20);
    chk_int(1'b0, "R2 clear beats set");
    wr(2'd1, 8'hFC);
    pulse(8'h40);
    ack_expect(8'h02, "R6 base wrap");
    wr(2'd2, 8'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_fixed();
    t_nesting();
    t_mask();
    t_spurious();
    t_auto_rot();
    t_spec_rot();
    t_smm();
    t_poll();
    t_clear_wins();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule